// File: doc/BRIEF.md
# Instruction Cache Line Controller

This block is a small set-associative instruction cache that the processor can only read. Each line carries one valid bit, so a line is either invalid or valid; instruction lines are never dirty. A fetch that hits returns the addressed word one cycle later. A fetch that misses asks memory for the whole line through a request/acknowledge pair, writes the line into the cache, marks it valid and returns the requested word.

The replacement way is an invalid way of the set when one exists. Otherwise a free-running pseudo-random sequence picks the way. A management input can drop a single line from the cache, coded as either an invalidate or a push; on an instruction line both have the same effect. A snoop port watches other bus masters. Their writes that hit a valid line remove that line when the 2-bit snoop-control code asks for snooping. Their reads are never acted on.

With the default parameters the cache has 4 sets and 4 ways, lines of 16 bytes made of 32-bit words, and 32-bit byte addresses. The address splits as byte offset [3:0] (word select [3:2]), set index [5:4] and tag [31:6].

Top module: `icache_line_ctrl`

## Requirements
- R1: After reset every line is invalid, `fetch_ready` is 1, and `rsp_valid` and `fill_req` are 0; the first fetch to any address misses.
- R2: An accepted fetch that misses raises `fill_req` on the next cycle with `fill_addr` equal to the fetch address with bits [3:0] cleared. Both hold until `fill_ack`. In the cycle after the acknowledge, `rsp_valid` is 1 and `rsp_data` is word `fetch_addr[3:2]` of `fill_data`, where word i sits at bits [32*i+31:32*i].
- R3: An accepted fetch to a resident line gives `rsp_valid` with the stored word in the next cycle and raises no `fill_req`.
- R4: Misses to a set that still has an invalid way fill an invalid way, so four different tags fetched into one empty set are all resident afterwards.
- R5: A miss to a set whose four ways are all valid replaces exactly one line, and the new line is resident afterwards.
- R6: `mgmt_op` 01 (invalidate) and 10 (push) make the line at `mgmt_addr` invalid if it is resident. Codes 00 and 11 do nothing. A command naming an absent line leaves every resident line valid.
- R7: A snooped write (`snp_valid`=1, `snp_write`=1) invalidates a matching valid line when `snp_ctl` is 01 or 10. Codes 00 and 11 leave it valid, and so does a write to another tag in the same set.
- R8: A snooped read (`snp_write`=0) never changes any line state, whatever the value of `snp_ctl`.
- R9: When a fetch and an invalidating snooped write to the same line arrive in the same cycle, the snoop wins and the fetch is handled as a miss.
- R10: `fetch_ready` is 0 while a line fill is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Processor fetch request, taken when `fetch_ready` is 1 |
| fetch_addr | input | 32 | Byte address of the fetched word |
| fetch_ready | output | 1 | Controller can accept a fetch |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` is valid |
| rsp_data | output | 32 | Fetched instruction word |
| fill_req | output | 1 | Line fill request to memory |
| fill_addr | output | 32 | Line-aligned fill address |
| fill_ack | input | 1 | Memory returns the line on `fill_data` |
| fill_data | input | 128 | Whole line, word 0 in the low bits |
| mgmt_op | input | 2 | 00 none, 01 invalidate, 10 push, 11 none |
| mgmt_addr | input | 32 | Address of the line named by the command |
| snp_valid | input | 1 | Another master's access is visible this cycle |
| snp_write | input | 1 | 1 = write, 0 = read |
| snp_ctl | input | 2 | 00 no snoop, 01 and 10 snoop, 11 reserved (no snoop) |
| snp_addr | input | 32 | Snooped byte address |

## Verification
Any fault in the valid bits or the tags shows up at the ports on the very next fetch to the affected line. A line that was wrongly kept shows as a hit with no `fill_req` where a fill was expected. A line that was wrongly dropped shows as an unexpected `fill_req`. A wrong tag or data write shows as a wrong `rsp_data` one cycle after the fetch or after the acknowledge. A bad victim choice shows when a set is filled: one of four freshly filled lines misses again, or the line just filled misses.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int WORDS   = 4;
  localparam int SETS    = 4;
  localparam int WAYS    = 4;
  localparam int LFSR_W  = 3;
  localparam int WSEL_W  = $clog2(WORDS);
  localparam int OFF_W   = WSEL_W + $clog2(DATA_W / 8);
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int TAG_W   = ADDR_W - OFF_W - SET_W;
  localparam int LINE_W  = WORDS * DATA_W;

  localparam logic [1:0] MG_INVAL = 2'b01;
  localparam logic [1:0] MG_PUSH  = 2'b10;

  typedef enum logic {ST_IDLE, ST_FILL} ctl_state_t;

  function automatic logic [SET_W-1:0] addr_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [WSEL_W-1:0] addr_word(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1 -: WSEL_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  function automatic logic [DATA_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                  input logic [WSEL_W-1:0] w);
    return line[w*DATA_W +: DATA_W];
  endfunction

  function automatic logic snoop_enabled(input logic [1:0] code);
    return (code == 2'b01) || (code == 2'b10);
  endfunction
endpackage

// File: rtl/icache_tags.sv
module icache_tags
  import icache_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [WAYS-1:0]   lk_valid,
  output logic [WAYS-1:0]   lk_hit,
  input  logic              fill_en,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              snp_en,
  input  logic [SET_W-1:0]  snp_set,
  input  logic [TAG_W-1:0]  snp_tag,
  input  logic              mg_en,
  input  logic [SET_W-1:0]  mg_set,
  input  logic [TAG_W-1:0]  mg_tag,
  output logic [SETS*WAYS-1:0] valid_flat
);
  logic [WAYS-1:0]  vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  snp_match;
  logic [WAYS-1:0]  mg_match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign snp_match[w] = snp_en && vld_q[snp_set][w] && (tag_q[snp_set][w] == snp_tag);
    assign mg_match[w]  = mg_en  && vld_q[mg_set][w]  && (tag_q[mg_set][w]  == mg_tag);
    // a line killed by a snoop this cycle no longer counts for lookup
    assign lk_valid[w]  = vld_q[lk_set][w] && !(snp_match[w] && (snp_set == lk_set));
    assign lk_hit[w]    = lk_valid[w] && (tag_q[lk_set][w] == lk_tag);

    // R7
    snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_match[w] |=> !vld_q[$past(snp_set)][w]);
    // R6
    mgmt_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mg_match[w] |=> !vld_q[$past(mg_set)][w]);
  end

  for (genvar s = 0; s < SETS; s++) begin : g_flat
    assign valid_flat[s*WAYS +: WAYS] = vld_q[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
      end
    end else begin
      if (fill_en) begin
        vld_q[fill_set][fill_way] <= 1'b1;
        tag_q[fill_set][fill_way] <= fill_tag;
      end
      for (int w = 0; w < WAYS; w++) begin
        if (snp_match[w]) vld_q[snp_set][w] <= 1'b0;
        if (mg_match[w])  vld_q[mg_set][w]  <= 1'b0;
      end
    end
  end

  // R5
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lk_hit));
endmodule

// File: rtl/icache_victim.sv
module icache_victim
  import icache_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  set_valid,
  output logic [WAY_W-1:0] victim
);
  logic [LFSR_W-1:0] lfsr_q;
  logic              has_free;
  logic [WAY_W-1:0]  free_way;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr_q <= LFSR_W'(1);
    else        lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_W-2]};
  end

  always_comb begin
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!set_valid[w]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  assign victim = has_free ? free_way : lfsr_q[WAY_W-1:0];

  // R4
  prefer_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid != '1) |-> !set_valid[victim]);
  // R5
  lfsr_live_chk: assert property (@(posedge clk) disable iff (!rst_n) lfsr_q != '0);
endmodule

// File: rtl/icache_data.sv
module icache_data
  import icache_pkg::*;
(
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [WAY_W-1:0]  rd_way,
  output logic [LINE_W-1:0] rd_line
);
  logic [LINE_W-1:0] mem_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_set][wr_way] <= wr_line;
  end

  assign rd_line = mem_q[rd_set][rd_way];
endmodule

// File: rtl/icache_line_ctrl.sv
module icache_line_ctrl
  import icache_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fill_req,
  output logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_ack,
  input  logic [LINE_W-1:0] fill_data,
  input  logic [1:0]        mgmt_op,
  input  logic [ADDR_W-1:0] mgmt_addr,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [1:0]        snp_ctl,
  input  logic [ADDR_W-1:0] snp_addr
);
  ctl_state_t        state_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [WAY_W-1:0]  vic_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [WAYS-1:0]   lk_valid, lk_hit;
  logic [WAY_W-1:0]  hit_way, victim;
  logic [LINE_W-1:0] rd_line;
  logic [SETS*WAYS-1:0] valid_flat;

  // named internal events
  logic acc, acc_hit, acc_miss, fill_done, snp_inval, mg_inval;

  assign snp_inval = snp_valid && snp_write && snoop_enabled(snp_ctl);
  assign mg_inval  = (mgmt_op == MG_INVAL) || (mgmt_op == MG_PUSH);
  assign acc       = fetch_req && (state_q == ST_IDLE);
  assign acc_hit   = acc && (|lk_hit);
  assign acc_miss  = acc && !(|lk_hit);
  assign fill_done = (state_q == ST_FILL) && fill_ack;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (lk_hit[w]) hit_way = WAY_W'(w);
  end

  icache_tags u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_set(addr_set(fetch_addr)), .lk_tag(addr_tag(fetch_addr)),
    .lk_valid(lk_valid), .lk_hit(lk_hit),
    .fill_en(fill_done), .fill_set(addr_set(req_addr_q)), .fill_way(vic_q),
    .fill_tag(addr_tag(req_addr_q)),
    .snp_en(snp_inval), .snp_set(addr_set(snp_addr)), .snp_tag(addr_tag(snp_addr)),
    .mg_en(mg_inval), .mg_set(addr_set(mgmt_addr)), .mg_tag(addr_tag(mgmt_addr)),
    .valid_flat(valid_flat)
  );

  icache_victim u_victim (
    .clk(clk), .rst_n(rst_n), .set_valid(lk_valid), .victim(victim)
  );

  icache_data u_data (
    .clk(clk), .wr_en(fill_done), .wr_set(addr_set(req_addr_q)), .wr_way(vic_q),
    .wr_line(fill_data), .rd_set(addr_set(fetch_addr)), .rd_way(hit_way),
    .rd_line(rd_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_addr_q  <= '0;
      vic_q       <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (acc_hit) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= pick_word(rd_line, addr_word(fetch_addr));
      end else if (acc_miss) begin
        state_q    <= ST_FILL;
        req_addr_q <= fetch_addr;
        vic_q      <= victim;
      end else if (fill_done) begin
        state_q     <= ST_IDLE;
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= pick_word(fill_data, addr_word(req_addr_q));
      end
    end
  end

  assign fetch_ready = (state_q == ST_IDLE);
  assign fill_req    = (state_q == ST_FILL);
  assign fill_addr   = line_base(req_addr_q);
  assign rsp_valid   = rsp_valid_q;
  assign rsp_data    = rsp_data_q;

  // R2
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr)));
  // R2
  fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && fill_ack) |=> (rsp_valid && !fill_req));
  // R3
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> (rsp_valid && !fill_req));
  // R8
  snoop_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_write && !mg_inval && !fill_done) |=> $stable(valid_flat));
  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !fetch_ready);
endmodule

// File: tb/tb_icache_line_ctrl.sv
module tb_icache_line_ctrl;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         fetch_req;
  logic [31:0]  fetch_addr;
  logic         fetch_ready;
  logic         rsp_valid;
  logic [31:0]  rsp_data;
  logic         fill_req;
  logic [31:0]  fill_addr;
  logic         fill_ack;
  logic [127:0] fill_data;
  logic [1:0]   mgmt_op;
  logic [31:0]  mgmt_addr;
  logic         snp_valid, snp_write;
  logic [1:0]   snp_ctl;
  logic [31:0]  snp_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icache_line_ctrl dut (.*);

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [127:0] mem_line(input logic [31:0] a);
    logic [127:0] l;
    for (int i = 0; i < 4; i++) l[32*i +: 32] = mem_word({a[31:4], 4'h0} + 32'(4*i));
    return l;
  endfunction

  // address from tag and set, word select
  function automatic logic [31:0] mk(input int tag, input int set, input int word);
    return (32'(tag) << 6) | (32'(set) << 4) | (32'(word) << 2);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one fetch; optional snoop write in the same cycle; returns hit
  task automatic fetch_snp(input logic [31:0] a, input bit with_snp, input logic [1:0] code,
                           input string req, output bit hit);
    @(negedge clk);
    fetch_req = 1; fetch_addr = a;
    if (with_snp) begin snp_valid = 1; snp_write = 1; snp_ctl = code; snp_addr = a; end
    @(negedge clk);
    fetch_req = 0; snp_valid = 0; snp_write = 0; snp_ctl = 0;
    hit = rsp_valid;
    if (!hit) begin
      chk(fill_req == 1, "R2 fill_req", fill_req, 1);
      chk(fill_addr == {a[31:4], 4'h0}, "R2 fill_addr", fill_addr, {a[31:4], 4'h0});
      chk(fetch_ready == 0, "R10 busy", fetch_ready, 0);
      @(negedge clk);
      chk(fill_req == 1 && fill_addr == {a[31:4], 4'h0}, "R2 hold", fill_addr, {a[31:4], 4'h0});
      fill_ack = 1; fill_data = mem_line(a);
      @(negedge clk);
      fill_ack = 0; fill_data = '0;
      chk(rsp_valid == 1 && fill_req == 0, "R2 rsp after ack", {rsp_valid, fill_req}, 2'b10);
    end
    chk(rsp_data == mem_word(a), {req, " data"}, rsp_data, mem_word(a));
  endtask

  task automatic fetch(input logic [31:0] a, input string req, output bit hit);
    fetch_snp(a, 0, 2'b00, req, hit);
  endtask

  task automatic expect_fetch(input logic [31:0] a, input bit exp_hit, input string req);
    bit h;
    fetch(a, req, h);
    chk(h == exp_hit, req, h, exp_hit);
  endtask

  task automatic snoop(input logic [31:0] a, input bit wr, input logic [1:0] code);
    @(negedge clk);
    snp_valid = 1; snp_write = wr; snp_ctl = code; snp_addr = a;
    @(negedge clk);
    snp_valid = 0; snp_write = 0; snp_ctl = 0;
  endtask

  task automatic mgmt(input logic [31:0] a, input logic [1:0] op);
    @(negedge clk);
    mgmt_op = op; mgmt_addr = a;
    @(negedge clk);
    mgmt_op = 0;
  endtask

  task automatic t_reset;
    chk(fetch_ready == 1 && rsp_valid == 0 && fill_req == 0, "R1 reset outputs",
        {fetch_ready, rsp_valid, fill_req}, 3'b100);
    expect_fetch(mk(3, 0, 1), 0, "R1 first fetch misses");
  endtask

  task automatic t_hit;
    expect_fetch(mk(3, 0, 0), 1, "R3 hit word0");
    expect_fetch(mk(3, 0, 3), 1, "R3 hit word3");
    expect_fetch(mk(3, 0, 2), 1, "R3 hit word2");
  endtask

  task automatic t_fill_set;
    for (int t = 1; t <= 4; t++) expect_fetch(mk(t, 1, t - 1), 0, "R4 cold miss");
    for (int t = 1; t <= 4; t++) expect_fetch(mk(t, 1, 0), 1, "R4 all resident");
  endtask

  task automatic t_replace;
    bit h;
    int misses = 0;
    expect_fetch(mk(9, 1, 1), 0, "R5 full-set miss");
    expect_fetch(mk(9, 1, 2), 1, "R5 new line resident");
    for (int t = 1; t <= 4; t++) begin
      if (misses == 0) begin
        fetch(mk(t, 1, 0), "R5 probe", h);
        if (!h) misses++;
      end
    end
    chk(misses == 1, "R5 one line replaced", misses, 1);
  endtask

  task automatic t_mgmt;
    expect_fetch(mk(5, 2, 0), 0, "R6 load");
    mgmt(mk(6, 2, 0), 2'b01);
    expect_fetch(mk(5, 2, 1), 1, "R6 absent line no effect");
    mgmt(mk(5, 2, 0), 2'b00);
    mgmt(mk(5, 2, 0), 2'b11);
    expect_fetch(mk(5, 2, 1), 1, "R6 codes 00/11 no effect");
    mgmt(mk(5, 2, 3), 2'b01);
    expect_fetch(mk(5, 2, 0), 0, "R6 invalidate");
    mgmt(mk(5, 2, 0), 2'b10);
    expect_fetch(mk(5, 2, 2), 0, "R6 push");
  endtask

  task automatic t_snoop;
    expect_fetch(mk(7, 3, 0), 0, "R7 load");
    snoop(mk(7, 3, 1), 1, 2'b00);
    expect_fetch(mk(7, 3, 0), 1, "R7 code 00 keeps");
    snoop(mk(7, 3, 1), 1, 2'b11);
    expect_fetch(mk(7, 3, 0), 1, "R7 code 11 keeps");
    snoop(mk(8, 3, 0), 1, 2'b01);
    expect_fetch(mk(7, 3, 0), 1, "R7 other tag keeps");
    snoop(mk(7, 3, 2), 1, 2'b01);
    expect_fetch(mk(7, 3, 0), 0, "R7 code 01 kills");
    snoop(mk(7, 3, 0), 1, 2'b10);
    expect_fetch(mk(7, 3, 1), 0, "R7 code 10 kills");
    for (int c = 0; c < 4; c++) snoop(mk(7, 3, 0), 0, 2'(c));
    expect_fetch(mk(7, 3, 3), 1, "R8 snooped reads ignored");
  endtask

  task automatic t_race;
    bit h;
    expect_fetch(mk(7, 3, 0), 1, "R9 resident before race");
    fetch_snp(mk(7, 3, 2), 1, 2'b01, "R9 race", h);
    chk(h == 0, "R9 snoop beats fetch", h, 0);
  endtask

  initial begin
    rst_n = 0; fetch_req = 0; fetch_addr = 0; fill_ack = 0; fill_data = 0;
    mgmt_op = 0; mgmt_addr = 0; snp_valid = 0; snp_write = 0; snp_ctl = 0; snp_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_hit;
    t_fill_set;
    t_replace;
    t_mgmt;
    t_snoop;
    t_race;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule